// File: doc/BRIEF.md
# Programmable I2C Bus Phase Timer

This block times the individual phases of an I2C bit for a master engine. The engine names one bus phase and pulses a start request. The block then counts that phase's programmed duration and reports its end. The phases are: SCL low, SCL high, START setup, START hold, STOP setup, data setup, data hold, and the release after a repeated START. Each duration is an 8-bit field in one of four packed configuration words. The engine uses the end-of-phase strobe to decide when to move SCL or SDA next. For example, it changes SDA only once the data-hold phase that follows a falling SCL edge has ended.

All phases are counted in ticks of one shared prescaler. The prescaler divides the input clock by a programmed divider plus one, and every phase runs for its field value plus one ticks. The divider and the duration are captured when a phase starts. Configuration writes made while a phase is running therefore cannot stretch or shorten it. Software computes the field values; the block only applies them.

Top module: `i2c_phase_timer`

## Requirements
- R1: After reset, `busy`, `done` and `tick` are all 0.
- R2: `phase_sel` picks the duration field as follows. 0 = SCL low, `cfg_w2[15:8]`. 1 = SCL high, `cfg_w2[7:0]`. 2 = START setup, `cfg_w1[31:24]`. 3 = START hold, `cfg_w1[23:16]`. 4 = STOP setup, `cfg_w1[15:8]`. 5 = data setup, `cfg_w2[31:24]`. 6 = data hold, `cfg_hold[7:0]`. 7 = repeated-START release, `cfg_w3[7:0]`. The divider D is always `cfg_w3[23:16]`. No other bit affects timing.
- R3: A start request sampled while idle sets `busy` at that edge. With field value N, `done` is high in the cycle that follows edge (N+1)*(D+1)+1 counted from that edge. `busy` falls at the same edge.
- R4: During a phase, `tick` pulses exactly N+1 times. The first pulse comes D+1 clocks after the start edge and each later pulse D+1 clocks after the one before. `tick` stays 0 while idle.
- R5: `done` is high for exactly one cycle per phase.
- R6: Changes to the configuration words while `busy` is 1 do not change the running phase. They apply to the next phase started while idle.
- R7: A start request while `busy` is 1 is ignored: it starts no second phase after the current one ends.
- R8: Boundary values work. D=0 gives a tick on every clock. N=255 with D=255 lasts 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_w1 | input | 32 | START setup, START hold, STOP setup fields |
| cfg_w2 | input | 32 | Data setup, SCL low, SCL high fields |
| cfg_w3 | input | 32 | Divider and repeated-START release fields |
| cfg_hold | input | 32 | Data hold field |
| phase_go | input | 1 | Start request, sampled while idle |
| phase_sel | input | 3 | Phase code (see R2) |
| tick | output | 1 | Prescaled tick during a phase |
| busy | output | 1 | A phase is being timed |
| done | output | 1 | One-cycle end-of-phase strobe |
| phase_cur | output | 3 | Code of the phase captured at start |

## Verification
Every phase code is run against words whose unused bytes hold junk. A decoder that takes the wrong byte or word would therefore end at a different cycle. The exact end cycle is checked for divider 0, a mid divider and the 255/255 extreme. This catches a missing "+1" on either the prescaler or the phase count, which would end one tick or one divider period early. Configuration writes and a second start request are made mid-phase. A design that reads live fields, or that queues the extra request, would change the running phase's length or start a phantom phase afterwards. Tick spacing and count are checked across each phase, and silence is checked after each one.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  typedef enum logic [2:0] {
    PH_SCL_LO = 3'd0,
    PH_SCL_HI = 3'd1,
    PH_STA_SU = 3'd2,
    PH_STA_HD = 3'd3,
    PH_STO_SU = 3'd4,
    PH_DAT_SU = 3'd5,
    PH_DAT_HD = 3'd6,
    PH_RS_REL = 3'd7
  } phase_e;

  // Returns {word index, bit offset} of a phase's duration field.
  function automatic logic [6:0] field_loc(phase_e p);
    case (p)
      PH_SCL_LO: field_loc = {2'd1, 5'd8};
      PH_SCL_HI: field_loc = {2'd1, 5'd0};
      PH_STA_SU: field_loc = {2'd0, 5'd24};
      PH_STA_HD: field_loc = {2'd0, 5'd16};
      PH_STO_SU: field_loc = {2'd0, 5'd8};
      PH_DAT_SU: field_loc = {2'd1, 5'd24};
      PH_DAT_HD: field_loc = {2'd3, 5'd0};
      default:   field_loc = {2'd2, 5'd0};
    endcase
  endfunction
endpackage

// File: rtl/i2c_tg_field_sel.sv
module i2c_tg_field_sel
  import i2c_tg_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_OFF = 16
) (
  input  phase_e              sel,
  input  logic [WORD_W-1:0]   w1,
  input  logic [WORD_W-1:0]   w2,
  input  logic [WORD_W-1:0]   w3,
  input  logic [WORD_W-1:0]   wh,
  output logic [CNT_W-1:0]    len,
  output logic [DIV_W-1:0]    div
);
  localparam int NWORDS = 4;
  logic [WORD_W-1:0] words [NWORDS];
  logic [6:0]        loc;

  always_comb begin
    words[0] = w1;
    words[1] = w2;
    words[2] = w3;
    words[3] = wh;
    loc      = field_loc(sel);
    len      = words[loc[6:5]][loc[4:0] +: CNT_W];
    div      = words[2][DIV_OFF +: DIV_W];
  end
endmodule

// File: rtl/i2c_tg_prescaler.sv
module i2c_tg_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tg_phase_ctr.sv
module i2c_tg_phase_ctr
  import i2c_tg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  phase_e           sel,
  input  logic [CNT_W-1:0] len_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             fin,
  output logic [DIV_W-1:0] div_q,
  output phase_e           phase_q
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt;

  assign fin = busy && tick && (cnt == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      div_q   <= '0;
      phase_q <= PH_SCL_LO;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy    <= 1'b1;
          cnt     <= '0;
          len_q   <= len_in;
          div_q   <= div_in;
          phase_q <= sel;
        end
      end else if (tick) begin
        if (cnt == len_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
  import i2c_tg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cfg_w1,
  input  logic [WORD_W-1:0] cfg_w2,
  input  logic [WORD_W-1:0] cfg_w3,
  input  logic [WORD_W-1:0] cfg_hold,
  input  logic              phase_go,
  input  logic [2:0]        phase_sel,
  output logic              tick,
  output logic              busy,
  output logic              done,
  output logic [2:0]        phase_cur
);
  localparam int DIV_OFF = 16;

  logic [CNT_W-1:0] sel_len;
  logic [DIV_W-1:0] sel_div;
  logic [DIV_W-1:0] div_q;
  logic             fin;
  phase_e           ph_q;

  i2c_tg_field_sel #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_OFF(DIV_OFF)) u_sel (
    .sel (phase_e'(phase_sel)),
    .w1  (cfg_w1),
    .w2  (cfg_w2),
    .w3  (cfg_w3),
    .wh  (cfg_hold),
    .len (sel_len),
    .div (sel_div)
  );

  i2c_tg_phase_ctr #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .go      (phase_go),
    .sel     (phase_e'(phase_sel)),
    .len_in  (sel_len),
    .div_in  (sel_div),
    .tick    (tick),
    .busy    (busy),
    .done    (done),
    .fin     (fin),
    .div_q   (div_q),
    .phase_q (ph_q)
  );

  i2c_tg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (busy && !fin),
    .div  (div_q),
    .tick (tick)
  );

  assign phase_cur = ph_q;

  AST_TICK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) tick |-> busy); // R4
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst) (tick && div_q != '0) |=> !tick); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && !tick)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) (busy && phase_go) |=> (busy || done)); // R7
endmodule

// File: tb/i2c_phase_timer_test.sv
module i2c_phase_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_w1, cfg_w2, cfg_w3, cfg_hold;
  logic        phase_go = 1'b0;
  logic [2:0]  phase_sel = 3'd0;
  logic        tick, busy, done;
  logic [2:0]  phase_cur;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  i2c_phase_timer uut (
    .clk(clk), .rst(rst), .cfg_w1(cfg_w1), .cfg_w2(cfg_w2), .cfg_w3(cfg_w3),
    .cfg_hold(cfg_hold), .phase_go(phase_go), .phase_sel(phase_sel),
    .tick(tick), .busy(busy), .done(done), .phase_cur(phase_cur)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one phase and checks its end cycle (R3), tick count and spacing (R4), pulse width (R5).
  task automatic run_phase(input logic [2:0] sel, input int n, input int d, input string req);
    int k = 0, ticks = 0, last = 0, badgap = 0, exp_k;
    exp_k = (n + 1) * (d + 1) + 1;
    @(negedge clk);
    phase_sel = sel;
    phase_go  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    phase_go = 1'b0;
    check(busy == 1'b1, "R3", "busy after start", busy, 1);
    while (k < exp_k + 8) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (tick) begin
        ticks++;
        if (k - last != d + 1) badgap++;
        last = k;
      end
      if (done) break;
    end
    check(k == exp_k, req, $sformatf("phase %0d end cycle", sel), k, exp_k);
    check(busy == 1'b0, "R3", "busy at done", busy, 0);
    check(ticks == n + 1, "R4", "tick count", ticks, n + 1);
    check(badgap == 0, "R4", "tick spacing errors", badgap, 0);
    @(negedge clk);
    check(done == 1'b0, "R5", "done width", done, 0);
    check(tick == 1'b0 && busy == 1'b0, "R4", "quiet after phase", tick, 0);
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0 && tick == 0, "R1", "reset outputs", {busy, done, tick}, 0);
  endtask

  task automatic t_field_map;
    cfg_w1   = {8'd3, 8'd4, 8'd5, 8'hEE};
    cfg_w2   = {8'd6, 8'hDD, 8'd7, 8'd8};
    cfg_w3   = {8'hBB, 8'd1, 8'hCC, 8'd9};
    cfg_hold = {24'hA5A5A5, 8'd2};
    run_phase(3'd0, 7, 1, "R2");
    run_phase(3'd1, 8, 1, "R2");
    run_phase(3'd2, 3, 1, "R2");
    run_phase(3'd3, 4, 1, "R2");
    run_phase(3'd4, 5, 1, "R2");
    run_phase(3'd5, 6, 1, "R2");
    run_phase(3'd6, 2, 1, "R2");
    run_phase(3'd7, 9, 1, "R2");
    check(phase_cur == 3'd7, "R2", "phase_cur", phase_cur, 7);
  endtask

  task automatic t_bounds;
    cfg_w3   = {8'h00, 8'd0, 8'h00, 8'd0};
    cfg_hold = 32'd0;
    run_phase(3'd6, 0, 0, "R8");
    cfg_w2 = {8'd0, 8'd0, 8'd255, 8'd0};
    cfg_w3 = {8'h00, 8'd255, 8'h00, 8'd0};
    run_phase(3'd0, 255, 255, "R8");
  endtask

  task automatic t_cfg_change;
    cfg_w2 = {8'd0, 8'd0, 8'd10, 8'd0};
    cfg_w3 = {8'h00, 8'd2, 8'h00, 8'd0};
    fork
      run_phase(3'd0, 10, 2, "R6");
      begin
        repeat (5) @(negedge clk);
        cfg_w2 = {8'd0, 8'd0, 8'd20, 8'd0};
        cfg_w3 = {8'h00, 8'd0, 8'h00, 8'd0};
      end
    join
    run_phase(3'd0, 20, 0, "R6");
  endtask

  task automatic t_go_busy;
    cfg_w1 = {8'd3, 8'd0, 8'd0, 8'd0};
    cfg_w3 = {8'h00, 8'd1, 8'h00, 8'd0};
    fork
      run_phase(3'd2, 3, 1, "R7");
      begin
        repeat (3) @(negedge clk);
        phase_sel = 3'd0;
        phase_go  = 1'b1;
        @(negedge clk);
        phase_go  = 1'b0;
      end
    join
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(busy == 1'b0, "R7", "no queued phase", busy, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_w1 = '0; cfg_w2 = '0; cfg_w3 = '0; cfg_hold = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_field_map();
    t_bounds();
    t_cfg_change();
    t_go_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule